// File: doc/BRIEF.md
# Byte-Serial SPI Master with Rate Divider

This block is an 8-bit SPI master core behind a small register interface. It has three registers. A control register holds the enable, interrupt-enable, master-select, clock polarity, clock phase and two-bit rate fields. A status register holds the completion flag, the write-collision flag and a double-speed bit. A data register starts a transfer when it is written and returns the received byte when it is read. Each transfer moves eight bits, most significant bit first. The core drives `sck`, shifts data out on `mosi` and shifts data in from `miso` at the same time.

The serial clock comes from the system clock through a divider. The divider follows an irregular table. A rate code of two bits selects a divisor of 4, 16, 64 or 128, and setting the double-speed bit halves that divisor. When a transfer ends, the core sets the completion flag and loads the received byte into the data register. While the flag is set and interrupts are enabled, the core holds an interrupt request high.

While the core is enabled and selected as master, a low level on `ss_n` is a mode fault. On a mode fault the core stops any transfer, drops out of master mode, returns `sck` to its idle level and sets the completion flag.

Top module: `spi_host_core`

## Requirements
- R1: After reset, all three registers read 0x00, and `sck`, `mosi` and `irq` are 0.
- R2: When no transfer is running, `sck` equals the polarity bit (control bit 3).
- R3: The rate code {status bit 0, control bits 6:5} selects the divisor. The codes 000 through 111 give 4, 16, 64, 128, 2, 8, 32 and 64. Each `sck` level lasts divisor/2 system clocks, so a transfer takes 16 half-periods.
- R4: With phase (control bit 4) at 0, `miso` is sampled on each leading `sck` edge and `mosi` changes on the trailing edges. Bit 7 of the byte appears on `mosi` in the cycle after the write.
- R5: With phase at 1, `mosi` changes on each leading edge, starting with bit 7, and `miso` is sampled on each trailing edge. The leading edge rises when polarity is 0 and falls when polarity is 1.
- R6: When the 16th half-period ends, the completion flag (status bit 7) is set and the data register (address 2) holds the eight received bits, first-sampled bit in bit 7.
- R7: `irq` is high exactly while the completion flag and the interrupt-enable bit (control bit 1) are both 1.
- R8: A one-cycle pulse on `irq_ack` clears the completion flag.
- R9: A data-register write during a transfer sets the write-collision flag (status bit 6). The write is ignored: the bits being sent and the final data register contents are unchanged.
- R10: A status read taken while the flag is set, followed by any data-register access, clears both the completion flag and the write-collision flag.
- R11: When enable (control bit 0) and master-select (control bit 2) are both 1 and `ss_n` is low, the core sets the completion flag, clears master-select, stops the transfer and puts `sck` back at its idle level.
- R12: Status bits 5 to 1 read as zero. Of the status bits, only bit 0 (double speed) can be written.
- R13: A data write while enable or master-select is 0 stores the byte without starting a transfer, so `sck` stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (drives the flag-clear sequence) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select input, low level is a mode fault |

## Verification
A wrong edge counter or a wrong divider count shows up on `sck` within one half-period, because the bench predicts the `sck` level on every clock. A wrong choice of shift or sample edge shows up on `mosi` at the next setup edge. On the receive side it appears only when the transfer ends, as a wrong byte in the data register. If the flag and collision state is wrong, `irq` and the status read go wrong in the cycle after completion, after a mode fault, or after the clearing access.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;

  localparam int unsigned MAX_HALF = 64;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // control register layout, bit 0 upward: enable, irq_en, master, polarity, phase, rate[1:0]
  typedef struct packed {
    logic [1:0] rate;
    logic       phase;
    logic       polarity;
    logic       master;
    logic       irq_en;
    logic       enable;
  } ctrl_t;

  // full divisor of the system clock for code {double, rate}
  function automatic int unsigned rate_divisor(input logic [2:0] code);
    case (code)
      3'b000:  return 4;
      3'b001:  return 16;
      3'b010:  return 64;
      3'b011:  return 128;
      3'b100:  return 2;
      3'b101:  return 8;
      3'b110:  return 32;
      default: return 64;
    endcase
  endfunction

  function automatic int unsigned half_period(input logic [2:0] code);
    return rate_divisor(code) / 2;
  endfunction

endpackage

// File: rtl/spi_clk_div.sv
`timescale 1ns/1ps
module spi_clk_div #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  import spi_host_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;

  assign half_m1 = CNT_W'(half_period(code) - 1);
  assign tick    = run && (cnt_q >= half_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_HALF));

endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          tick,
  input  logic          phase,
  input  logic [DW-1:0] tx_byte,
  input  logic          miso,
  output logic          busy,
  output logic          level,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_final
);
  localparam int EW = $clog2(2*DW);
  localparam logic [EW-1:0] LAST = EW'(2*DW-1);

  logic          busy_q, level_q, mosi_q;
  logic [EW-1:0] edge_q;
  logic [DW-1:0] tx_q, rx_q, rx_next;
  logic          edge_ev, leading, is_last, sample_ev, setup_ev;

  assign edge_ev   = busy_q && tick;
  assign leading   = ~edge_q[0];
  assign is_last   = (edge_q == LAST);
  assign sample_ev = edge_ev && (leading ^ phase);
  assign setup_ev  = edge_ev && !(leading ^ phase) && !is_last;
  assign done      = edge_ev && is_last;
  assign rx_next   = {rx_q[DW-2:0], miso};
  assign rx_final  = sample_ev ? rx_next : rx_q;

  assign busy  = busy_q;
  assign level = level_q;
  assign mosi  = mosi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      level_q <= 1'b0;
      mosi_q  <= 1'b0;
      edge_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else if (abort) begin
      busy_q  <= 1'b0;
      level_q <= 1'b0;
      edge_q  <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      level_q <= 1'b0;
      edge_q  <= '0;
      rx_q    <= '0;
      if (!phase) begin
        mosi_q <= tx_byte[DW-1];
        tx_q   <= {tx_byte[DW-2:0], 1'b0};
      end else begin
        tx_q   <= tx_byte;
      end
    end else if (edge_ev) begin
      level_q <= ~level_q;
      edge_q  <= edge_q + 1'b1;
      if (is_last)   busy_q <= 1'b0;
      if (sample_ev) rx_q   <= rx_next;
      if (setup_ev) begin
        mosi_q <= tx_q[DW-1];
        tx_q   <= {tx_q[DW-2:0], 1'b0};
      end
    end
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy_q && !level_q));

endmodule

// File: rtl/spi_host_core.sv
`timescale 1ns/1ps
module spi_host_core #(
  parameter int DW    = 8,
  parameter int CNT_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  input  logic          irq_ack,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  input  logic          ss_n
);
  import spi_host_pkg::*;

  ctrl_t         ctrl_q;
  logic          dbl_q, flag_q, wcol_q, armed_q;
  logic [DW-1:0] data_q;

  logic wr_ctrl, wr_stat, wr_data, rd_stat, rd_data;
  logic busy, level, tick, done_ev, fault_ev, start_ev, abort_ev;
  logic clear_ev, coll_ev;
  logic [DW-1:0] rx_final;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign rd_stat = reg_rd && (reg_addr == ADDR_STAT);
  assign rd_data = reg_rd && (reg_addr == ADDR_DATA);

  assign fault_ev = ctrl_q.enable && ctrl_q.master && !ss_n;
  assign abort_ev = fault_ev || !ctrl_q.enable;
  assign start_ev = wr_data && !busy && ctrl_q.enable && ctrl_q.master && !fault_ev;
  assign coll_ev  = wr_data && busy;
  assign clear_ev = armed_q && (wr_data || rd_data);

  spi_clk_div #(.CNT_W(CNT_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .code ({dbl_q, ctrl_q.rate}),
    .tick (tick)
  );

  spi_shift_engine #(.DW(DW)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_ev),
    .abort   (abort_ev),
    .tick    (tick),
    .phase   (ctrl_q.phase),
    .tx_byte (reg_wdata),
    .miso    (miso),
    .busy    (busy),
    .level   (level),
    .mosi    (mosi),
    .done    (done_ev),
    .rx_final(rx_final)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      dbl_q   <= 1'b0;
      flag_q  <= 1'b0;
      wcol_q  <= 1'b0;
      armed_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[6:0]);
      if (fault_ev) ctrl_q.master <= 1'b0;
      if (wr_stat) dbl_q <= reg_wdata[0];

      if (done_ev) data_q <= rx_final;
      else if (wr_data && !busy) data_q <= reg_wdata;

      if (done_ev || fault_ev)      flag_q <= 1'b1;
      else if (irq_ack || clear_ev) flag_q <= 1'b0;

      if (coll_ev)       wcol_q <= 1'b1;
      else if (clear_ev) wcol_q <= 1'b0;

      if (rd_stat && flag_q) armed_q <= 1'b1;
      else if (clear_ev)     armed_q <= 1'b0;
    end
  end

  assign sck = ctrl_q.polarity ^ level;
  assign irq = flag_q && ctrl_q.irq_en;

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {1'b0, ctrl_q};
      ADDR_STAT: reg_rdata = {flag_q, wcol_q, {(DW-3){1'b0}}, dbl_q};
      ADDR_DATA: reg_rdata = data_q;
      default:   reg_rdata = '0;
    endcase
  end

  // R6
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> flag_q);

  // R9
  wcol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol_q) |-> $past(wr_data && busy));

  // R11
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ev |=> (!ctrl_q.master && !busy));

endmodule

// File: tb/tb_spi_host_core.sv
`timescale 1ns/1ps
module tb_spi_host_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, irq_ack = 1'b0, sck, mosi, miso = 1'b0, ss_n = 1'b1;

  int checks = 0;
  int fails  = 0;
  logic prev_mosi = 1'b0;

  always #4 clk = ~clk;

  spi_host_core dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic int bench_div(input logic [2:0] c);
    int d;
    d = (c[1:0] == 2'b11) ? 128 : (4 << (2 * int'(c[1:0])));
    if (c[2]) d = d / 2;
    return d;
  endfunction

  function automatic logic exp_mosi(input logic pha, input logic [7:0] tx, input int e, input logic prev);
    int s;
    if (!pha) s = e / 2;
    else if (e == 0) return prev;
    else s = (e - 1) / 2;
    if (s > 7) s = 7;
    return tx[7 - s];
  endfunction

  function automatic logic slave_bit(input logic pha, input logic [7:0] sl, input int e);
    int sd;
    sd = pha ? e / 2 : (e + 1) / 2;
    return (sd > 7) ? 1'b0 : sl[7 - sd];
  endfunction

  task automatic run_xfer(input logic pol, input logic pha, input logic [2:0] code,
                          input logic [7:0] tx, input logic [7:0] sl, input logic ien,
                          input int coll_k);
    int half, total;
    logic [7:0] v;
    half  = bench_div(code) / 2;
    total = 16 * half;
    wr_reg(2'd0, {1'b0, code[1:0], pha, pol, 1'b1, ien, 1'b1});
    wr_reg(2'd1, {7'd0, code[2]});
    @(negedge clk); reg_addr = 2'd2; reg_wdata = tx; reg_wr = 1'b1;
    for (int k = 0; k <= total; k++) begin
      int e;
      @(negedge clk);
      reg_wr = 1'b0;
      e = k / half;
      if (e > 16) e = 16;
      miso = slave_bit(pha, sl, e);
      // R2 R3 R5: sck level per half-period
      check("R3 sck", sck, pol ^ e[0] & (e < 16));
      // R4 R5: mosi setup edges
      check(pha ? "R5 mosi" : "R4 mosi", mosi, exp_mosi(pha, tx, e, prev_mosi));
      // R7
      check("R7 irq", irq, (k == total) ? ien : 1'b0);
      if (k == coll_k) begin reg_addr = 2'd2; reg_wdata = 8'h3C; reg_wr = 1'b1; end
    end
    prev_mosi = tx[0];
    rd_reg(2'd2, v);  check("R6 data", v, sl);
    rd_reg(2'd1, v);  check("R6 status", v, {1'b1, (coll_k >= 0), 5'd0, code[2]});
    if (coll_k >= 0) begin
      rd_reg(2'd2, v);
      rd_reg(2'd1, v);  check("R10 cleared", v, {7'd0, code[2]});
    end else begin
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      check("R8 irq after ack", irq, 1'b0);
      rd_reg(2'd1, v);  check("R8 status", v, {7'd0, code[2]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    check("R1 sck", sck, 0); check("R1 mosi", mosi, 0); check("R1 irq", irq, 0);
    rd_reg(2'd0, v); check("R1 ctrl", v, 8'h00);
    rd_reg(2'd1, v); check("R1 status", v, 8'h00);
    rd_reg(2'd2, v); check("R1 data", v, 8'h00);

    // R12
    wr_reg(2'd1, 8'hFF); rd_reg(2'd1, v); check("R12 status bits", v, 8'h01);
    wr_reg(2'd1, 8'h00); rd_reg(2'd1, v); check("R12 status clear", v, 8'h00);

    // R2 R13: polarity 1, disabled core ignores start
    wr_reg(2'd0, 8'h08);
    check("R2 idle high", sck, 1'b1);
    wr_reg(2'd2, 8'hA5);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R13 sck idle", sck, 1'b1);
      check("R13 mosi", mosi, prev_mosi);
    end
    rd_reg(2'd2, v); check("R13 data stored", v, 8'hA5);
    rd_reg(2'd1, v); check("R13 no flag", v, 8'h00);
    // R13: enabled but not master
    wr_reg(2'd0, 8'h09);
    wr_reg(2'd2, 8'h5C);
    repeat (6) begin @(negedge clk); check("R13 not master", sck, 1'b1); end

    // transfers across modes and rates (R3 R4 R5 R6 R7 R8 R9 R10)
    run_xfer(1'b0, 1'b0, 3'b000, 8'hA5, 8'h3C, 1'b1, -1);
    run_xfer(1'b1, 1'b1, 3'b100, 8'h5A, 8'hC3, 1'b0, -1);
    run_xfer(1'b0, 1'b1, 3'b011, 8'h81, 8'h7E, 1'b1, -1);
    run_xfer(1'b1, 1'b0, 3'b111, 8'h96, 8'h69, 1'b1, 40);
    run_xfer(1'b0, 1'b0, 3'b101, 8'hFF, 8'h00, 1'b0, -1);
    run_xfer(1'b1, 1'b1, 3'b110, 8'h0F, 8'hF1, 1'b1, -1);
    run_xfer(1'b0, 1'b1, 3'b001, 8'h33, 8'hCC, 1'b1, 7);
    run_xfer(1'b1, 1'b0, 3'b010, 8'hE7, 8'h18, 1'b0, -1);

    // R11: mode fault mid-transfer, polarity 1, phase 0, divisor 4
    wr_reg(2'd0, 8'h0F);
    wr_reg(2'd1, 8'h00);
    @(negedge clk); reg_addr = 2'd2; reg_wdata = 8'hF0; reg_wr = 1'b1;
    for (int k = 0; k <= 4; k++) begin
      int e;
      @(negedge clk);
      reg_wr = 1'b0;
      e = k / 2;
      check("R11 pre sck", sck, 1'b1 ^ e[0]);
    end
    ss_n = 1'b0;
    @(negedge clk);
    ss_n = 1'b1;
    check("R11 sck idle", sck, 1'b1);
    check("R11 mosi held", mosi, 1'b1);
    check("R11 irq", irq, 1'b1);
    repeat (4) begin @(negedge clk); check("R11 stays idle", sck, 1'b1); end
    prev_mosi = 1'b1;
    rd_reg(2'd0, v); check("R11 master cleared", v, 8'h0B);
    rd_reg(2'd1, v); check("R11 flag", v, 8'h80);
    rd_reg(2'd2, v); check("R11 data", v, 8'hF0);
    rd_reg(2'd1, v); check("R10 cleared after fault", v, 8'h00);
    check("R7 irq low", irq, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule